// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Two Output Lines

This block collects up to 256 interrupt sources and drives two processor request lines: a normal line and a fast line. Each source has a pending flag, an enable flag, a routing bit choosing the line it feeds, an 8-bit priority and a 32-bit handler address. Sources are grouped in banks of 32, and source `i` sits in bank `i/32` at bit `i%32`. Pending flags are set by a hardware pulse on `src_set`, or by software writing ones to the bank's pending register. Software clears them by writing ones to the bank's status register.

For each line, the controller picks the most urgent source that is pending and enabled. It registers that choice and presents it at the ports and through the register interface. On the normal line, reading the handler-address register marks the chosen source as being serviced. Its priority is pushed onto a small stack. While it is being serviced, only a more urgent source can raise the normal line again. Any write to the same register ends the service and pops the stack. The fast line does not nest: reading its handler-address register masks the line until that register is written. When no valid source is chosen, a programmable fallback address is returned instead.

The bus is a single-cycle word interface: a write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high, and read data is combinational.

Top module: `vic_top`

## Requirements
- R1: Writing ones to bank `b`'s pending register (word address 0x100+8b) sets those sources pending, and zero bits change nothing. A high bit on `src_set` for one cycle also sets that source pending. Reading the pending register returns the pending flags.
- R2: Writing ones to bank `b`'s status register (0x101+8b) clears those pending flags. Reading it returns pending AND enabled.
- R3: Writing ones to 0x102+8b turns those enables on, and writing ones to 0x103+8b turns them off. Other bits are kept. Both addresses read back the enable flags.
- R4: Routing register 0x106+8b holds one bit per source: 1 feeds the fast line and 0 feeds the normal line. Reading 0x104+8b returns pending AND enabled AND NOT routed. Reading 0x105+8b returns pending AND enabled AND routed.
- R5: On each line, only sources that are pending, enabled and routed to that line compete. The lowest priority value wins (priority of source `i` is at 0x400+i, bits 7:0). On a tie, the lower source index wins.
- R6: `irq_o`/`irq_idx_o` and `fiq_o`/`fiq_idx_o` are registered. A bus write that changes the choice is reflected at the second rising edge counted from the edge that takes the write.
- R7: The index registers (0x000 normal, 0x001 fast) read {valid at bit 31, winning priority at bits 15:8, index at bits 7:0}, with all other bits zero. The handler-address registers (0x002 normal, 0x003 fast) return the stored address (0x800+i) of the chosen source.
- R8: A handler-address read with no valid chosen source returns the fallback register (0x004).
- R9: A read of 0x002 while `irq_o` is high pushes the chosen priority. Afterwards, only sources with a strictly lower priority value than the top of the stack drive the normal line. The stack holds 4 levels.
- R10: Any write to 0x002 pops one level. A write with an empty stack has no effect.
- R11: A read of 0x003 while `fiq_o` is high masks the fast line. Any write to 0x003 unmasks it.
- R12: After reset, all flags, priorities, addresses and the stack are zero or empty, and both lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 256 | Per-source hardware pending pulse |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_idx_o | output | 8 | Index chosen for the normal line |
| fiq_idx_o | output | 8 | Index chosen for the fast line |

## Verification
A corrupted flag register or a wrong arbitration result shows up within two clock edges as a wrong line level or index. It also shows as a mismatch between the per-bank status words and the pending and enable values written. A stack that pushes or pops wrongly is invisible until the next service boundary. There, an equal-priority source raising the normal line, or a more urgent source failing to raise it, exposes the fault. The scenarios therefore build a two-level nest and unwind it, checking the line after every push and pop.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_NSRC   = 256;
    localparam int VIC_BANK_W = 32;
    localparam int VIC_PW     = 8;
    localparam int VIC_IW     = $clog2(VIC_NSRC);
    localparam int VIC_AW     = 12;
    localparam int VIC_DW     = 32;
    localparam int VIC_STK    = 4;

    localparam int A_IRQ_IDX  = 'h000;
    localparam int A_FIQ_IDX  = 'h001;
    localparam int A_IRQ_VEC  = 'h002;
    localparam int A_FIQ_VEC  = 'h003;
    localparam int A_DFLT     = 'h004;
    localparam int A_BANK     = 'h100;
    localparam int A_BSTRIDE  = 8;
    localparam int A_PRIO     = 'h400;
    localparam int A_VEC      = 'h800;

    typedef enum logic [2:0] {
        BK_PEND   = 3'd0,
        BK_STS    = 3'd1,
        BK_ENSET  = 3'd2,
        BK_ENCLR  = 3'd3,
        BK_IRQSTS = 3'd4,
        BK_FIQSTS = 3'd5,
        BK_ROUTE  = 3'd6
    } bank_reg_e;

    typedef struct packed {
        logic              valid;
        logic [VIC_PW-1:0] prio;
        logic [VIC_IW-1:0] idx;
    } pick_t;

    function automatic logic [VIC_AW-1:0] bank_addr(int b, bank_reg_e r);
        return VIC_AW'(A_BANK + b * A_BSTRIDE + int'(r));
    endfunction
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int NSRC = VIC_NSRC
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [VIC_AW-1:0]                addr,
    input  logic [VIC_DW-1:0]                wdata,
    input  logic [NSRC-1:0]                  src_set,
    output logic [NSRC-1:0]                  pend,
    output logic [NSRC-1:0]                  en,
    output logic [NSRC-1:0]                  route,
    output logic [NSRC-1:0][VIC_PW-1:0]      prio,
    output logic [NSRC-1:0][VIC_DW-1:0]      vec,
    output logic [VIC_DW-1:0]                dflt
);
    localparam int NBANK = NSRC / VIC_BANK_W;
    localparam int W     = VIC_BANK_W;

    logic [NSRC-1:0] set_m, clr_m, ens_m, enc_m, rt_m, rt_v;
    logic            prio_hit, vec_hit;
    logic [VIC_IW-1:0] slot_p, slot_v;

    always_comb begin
        set_m = '0; clr_m = '0; ens_m = '0; enc_m = '0; rt_m = '0; rt_v = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (wr_en && addr == bank_addr(b, BK_PEND))  set_m[b*W +: W] = wdata;
            if (wr_en && addr == bank_addr(b, BK_STS))   clr_m[b*W +: W] = wdata;
            if (wr_en && addr == bank_addr(b, BK_ENSET)) ens_m[b*W +: W] = wdata;
            if (wr_en && addr == bank_addr(b, BK_ENCLR)) enc_m[b*W +: W] = wdata;
            if (wr_en && addr == bank_addr(b, BK_ROUTE)) begin
                rt_m[b*W +: W] = '1;
                rt_v[b*W +: W] = wdata;
            end
        end
    end

    assign prio_hit = wr_en && addr >= VIC_AW'(A_PRIO) && addr < VIC_AW'(A_PRIO + NSRC);
    assign vec_hit  = wr_en && addr >= VIC_AW'(A_VEC)  && addr < VIC_AW'(A_VEC + NSRC);
    assign slot_p   = VIC_IW'(addr - VIC_AW'(A_PRIO));
    assign slot_v   = VIC_IW'(addr - VIC_AW'(A_VEC));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            en    <= '0;
            route <= '0;
            prio  <= '0;
            vec   <= '0;
            dflt  <= '0;
        end else begin
            pend  <= (pend & ~clr_m) | set_m | src_set;
            en    <= (en | ens_m) & ~enc_m;
            route <= (route & ~rt_m) | (rt_v & rt_m);
            if (prio_hit) prio[slot_p] <= wdata[VIC_PW-1:0];
            if (vec_hit)  vec[slot_v]  <= wdata;
            if (wr_en && addr == VIC_AW'(A_DFLT)) dflt <= wdata;
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NSRC = VIC_NSRC
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][VIC_PW-1:0] prio,
    output pick_t                       pick
);
    // Strict less-than while scanning upward keeps the lowest index on ties.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!pick.valid || prio[i] < pick.prio)) begin
                pick.valid = 1'b1;
                pick.prio  = prio[i];
                pick.idx   = VIC_IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack
    import vic_pkg::*;
#(
    parameter int DEPTH = VIC_STK
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [VIC_PW-1:0]              push_prio,
    input  logic                           pop,
    output logic [VIC_PW:0]                thresh,
    output logic [$clog2(DEPTH+1)-1:0]     depth
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [VIC_PW-1:0] stk [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
            for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
        end else if (push && depth < CW'(DEPTH)) begin
            stk[SW'(depth)] <= push_prio;
            depth           <= depth + CW'(1);
        end else if (pop && depth != '0) begin
            depth <= depth - CW'(1);
        end
    end

    // Empty stack: threshold above every 8-bit priority.
    assign thresh = (depth == '0) ? {1'b1, {VIC_PW{1'b0}}}
                                  : {1'b0, stk[SW'(depth - CW'(1))]};
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NSRC  = VIC_NSRC,
    parameter int DEPTH = VIC_STK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src_set,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [VIC_AW-1:0]   bus_addr,
    input  logic [VIC_DW-1:0]   bus_wdata,
    output logic [VIC_DW-1:0]   bus_rdata,
    output logic                irq_o,
    output logic                fiq_o,
    output logic [VIC_IW-1:0]   irq_idx_o,
    output logic [VIC_IW-1:0]   fiq_idx_o
);
    localparam int NBANK = NSRC / VIC_BANK_W;
    localparam int W     = VIC_BANK_W;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int ZW    = VIC_DW - 1 - VIC_PW - VIC_IW;

    logic wr_en, rd_en;
    logic [NSRC-1:0]             pend, en, route;
    logic [NSRC-1:0][VIC_PW-1:0] prio;
    logic [NSRC-1:0][VIC_DW-1:0] vec;
    logic [VIC_DW-1:0]           dflt;
    logic [NSRC-1:0]             irq_cand, fiq_cand;
    pick_t                       irq_pick, fiq_pick, irq_q, fiq_q;
    logic [VIC_PW:0]             thresh;
    logic [CW-1:0]               stk_depth;
    logic                        fiq_busy;
    logic irq_take, irq_eoi, fiq_take, fiq_eoi;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    vic_regfile #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .src_set(src_set), .pend(pend), .en(en), .route(route),
        .prio(prio), .vec(vec), .dflt(dflt)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_qual
        assign irq_cand[i] = pend[i] & en[i] & ~route[i] & ({1'b0, prio[i]} < thresh);
        assign fiq_cand[i] = pend[i] & en[i] &  route[i] & ~fiq_busy;
    end

    vic_arbiter #(.NSRC(NSRC)) u_arb_irq (.cand(irq_cand), .prio(prio), .pick(irq_pick));
    vic_arbiter #(.NSRC(NSRC)) u_arb_fiq (.cand(fiq_cand), .prio(prio), .pick(fiq_pick));

    assign irq_take = rd_en && bus_addr == VIC_AW'(A_IRQ_VEC) && irq_q.valid;
    assign irq_eoi  = wr_en && bus_addr == VIC_AW'(A_IRQ_VEC);
    assign fiq_take = rd_en && bus_addr == VIC_AW'(A_FIQ_VEC) && fiq_q.valid;
    assign fiq_eoi  = wr_en && bus_addr == VIC_AW'(A_FIQ_VEC);

    vic_prio_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst(rst), .push(irq_take), .push_prio(irq_q.prio),
        .pop(irq_eoi), .thresh(thresh), .depth(stk_depth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= '0;
            fiq_q    <= '0;
            fiq_busy <= 1'b0;
        end else begin
            irq_q <= irq_pick;
            fiq_q <= fiq_pick;
            if (fiq_take)     fiq_busy <= 1'b1;
            else if (fiq_eoi) fiq_busy <= 1'b0;
        end
    end

    assign irq_o     = irq_q.valid;
    assign fiq_o     = fiq_q.valid;
    assign irq_idx_o = irq_q.idx;
    assign fiq_idx_o = fiq_q.idx;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == VIC_AW'(A_IRQ_IDX))
            bus_rdata = {irq_q.valid, {ZW{1'b0}}, irq_q.prio, irq_q.idx};
        if (bus_addr == VIC_AW'(A_FIQ_IDX))
            bus_rdata = {fiq_q.valid, {ZW{1'b0}}, fiq_q.prio, fiq_q.idx};
        if (bus_addr == VIC_AW'(A_IRQ_VEC))
            bus_rdata = irq_q.valid ? vec[irq_q.idx] : dflt;
        if (bus_addr == VIC_AW'(A_FIQ_VEC))
            bus_rdata = fiq_q.valid ? vec[fiq_q.idx] : dflt;
        if (bus_addr == VIC_AW'(A_DFLT))
            bus_rdata = dflt;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == bank_addr(b, BK_PEND))   bus_rdata = pend[b*W +: W];
            if (bus_addr == bank_addr(b, BK_STS))    bus_rdata = pend[b*W +: W] & en[b*W +: W];
            if (bus_addr == bank_addr(b, BK_ENSET) ||
                bus_addr == bank_addr(b, BK_ENCLR))  bus_rdata = en[b*W +: W];
            if (bus_addr == bank_addr(b, BK_IRQSTS)) bus_rdata = pend[b*W +: W] & en[b*W +: W] & ~route[b*W +: W];
            if (bus_addr == bank_addr(b, BK_FIQSTS)) bus_rdata = pend[b*W +: W] & en[b*W +: W] & route[b*W +: W];
            if (bus_addr == bank_addr(b, BK_ROUTE))  bus_rdata = route[b*W +: W];
        end
        if (bus_addr >= VIC_AW'(A_PRIO) && bus_addr < VIC_AW'(A_PRIO + NSRC))
            bus_rdata = VIC_DW'(prio[VIC_IW'(bus_addr - VIC_AW'(A_PRIO))]);
        if (bus_addr >= VIC_AW'(A_VEC) && bus_addr < VIC_AW'(A_VEC + NSRC))
            bus_rdata = vec[VIC_IW'(bus_addr - VIC_AW'(A_VEC))];
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
#(
    parameter int NSRC  = VIC_NSRC,
    parameter int DEPTH = VIC_STK
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             irq_o,
    input logic                             fiq_o,
    input logic [VIC_IW-1:0]                irq_idx,
    input logic [VIC_IW-1:0]                fiq_idx,
    input logic [NSRC-1:0]                  pend,
    input logic [NSRC-1:0]                  en,
    input logic [NSRC-1:0]                  route,
    input logic [NSRC-1:0][VIC_PW-1:0]      prio,
    input logic [VIC_PW:0]                  thresh,
    input logic [$clog2(DEPTH+1)-1:0]       depth,
    input logic                             bus_sel,
    input logic                             bus_wr,
    input logic [VIC_AW-1:0]                bus_addr
);
    logic [NSRC-1:0]             pend_d, en_d, route_d;
    logic [NSRC-1:0][VIC_PW-1:0] prio_d;
    logic [VIC_PW:0]             thresh_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_d <= '0; en_d <= '0; route_d <= '0; prio_d <= '0; thresh_d <= '0;
        end else begin
            pend_d <= pend; en_d <= en; route_d <= route; prio_d <= prio; thresh_d <= thresh;
        end
    end

    AST_IRQ_SRC_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_d[irq_idx] && en_d[irq_idx] && !route_d[irq_idx])); // R5
    AST_FIQ_SRC_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (pend_d[fiq_idx] && en_d[fiq_idx] && route_d[fiq_idx])); // R4
    AST_LINES_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (irq_o && fiq_o) |-> irq_idx != fiq_idx); // R4
    AST_IRQ_BELOW_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ({1'b0, prio_d[irq_idx]} < thresh_d)); // R9
    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth <= ($clog2(DEPTH+1))'(DEPTH)); // R9
    AST_EOI_POPS: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == VIC_AW'(A_IRQ_VEC) && depth != '0)
        |=> depth == $past(depth) - 1'b1); // R10
endmodule

bind vic_top vic_checker #(.NSRC(NSRC), .DEPTH(DEPTH)) u_vic_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_idx(irq_idx_o), .fiq_idx(fiq_idx_o),
    .pend(pend), .en(en), .route(route), .prio(prio),
    .thresh(thresh), .depth(stk_depth),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/test_vic_top.sv
module test_vic_top;
    logic         clk = 1'b0;
    logic         rst;
    logic [255:0] src_set;
    logic         bus_sel, bus_wr;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata, bus_rdata;
    logic         irq_o, fiq_o;
    logic [7:0]   irq_idx_o, fiq_idx_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    vic_top i_vic_top (
        .clk(clk), .rst(rst), .src_set(src_set),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .irq_idx_o(irq_idx_o), .fiq_idx_o(fiq_idx_o)
    );

    function automatic logic [11:0] bk(int b, int k);
        return 12'(32'h100 + b * 8 + k);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 irq_o", 32'(irq_o), 0);
        chk("R12 fiq_o", 32'(fiq_o), 0);
        rd(12'h000, d); chk("R12 irq index", d, 0);
        rd(12'h004, d); chk("R12 fallback", d, 0);
        rd(bk(0, 0), d); chk("R12 pending", d, 0);
        rd(12'h800, d);  chk("R12 vector", d, 0);
    endtask

    task automatic t_pending_enable();
        logic [31:0] d;
        wr(bk(0, 0), 32'h20);
        rd(bk(0, 0), d); chk("R1 set pending", d, 32'h20);
        wr(bk(0, 0), 32'h0);
        rd(bk(0, 0), d); chk("R1 zero write", d, 32'h20);
        rd(bk(0, 1), d); chk("R2 status unenabled", d, 0);
        settle(); chk("R5 disabled silent", 32'(irq_o), 0);
        wr(bk(0, 2), 32'h60);
        chk("R6 not yet", 32'(irq_o), 0);
        @(negedge clk);
        chk("R6 second edge", 32'(irq_o), 1);
        chk("R6 idx", 32'(irq_idx_o), 5);
        wr(bk(0, 3), 32'h40);
        rd(bk(0, 2), d); chk("R3 enable set/clr", d, 32'h20);
        rd(bk(0, 3), d); chk("R3 enable clr readback", d, 32'h20);
        rd(12'h000, d);  chk("R7 index word", d, 32'h8000_0005);
        rd(bk(0, 1), d); chk("R2 status", d, 32'h20);
        rd(bk(0, 4), d); chk("R4 irq status", d, 32'h20);
        wr(bk(0, 3), 32'h20); settle();
        chk("R3 disabled drops line", 32'(irq_o), 0);
        wr(bk(0, 2), 32'h20); settle();
        chk("R3 re-enabled", 32'(irq_o), 1);
        wr(bk(0, 1), 32'h20); settle();
        chk("R2 cleared line", 32'(irq_o), 0);
        rd(bk(0, 0), d); chk("R2 pending cleared", d, 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(12'h400 + 12'd40, 3);  wr(12'h400 + 12'd70, 3);  wr(12'h400 + 12'd100, 1);
        wr(12'h800 + 12'd40, 32'h1000_0040);
        wr(12'h800 + 12'd70, 32'h1000_0070);
        wr(12'h800 + 12'd200, 32'h1000_0200);
        rd(12'h400 + 12'd100, d); chk("R5 prio readback", d, 1);
        wr(bk(1, 2), 32'h100); wr(bk(2, 2), 32'h40); wr(bk(3, 2), 32'h10);
        wr(bk(1, 0), 32'h100); wr(bk(2, 0), 32'h40); wr(bk(3, 0), 32'h10);
        settle();
        chk("R5 lowest value wins", 32'(irq_idx_o), 100);
        wr(bk(3, 1), 32'h10); settle();
        chk("R5 tie lower index", 32'(irq_idx_o), 40);
    endtask

    task automatic t_route_fast();
        logic [31:0] d;
        wr(bk(2, 6), 32'h40); settle();
        chk("R4 fast line", 32'(fiq_o), 1);
        chk("R4 fast idx", 32'(fiq_idx_o), 70);
        chk("R4 normal idx", 32'(irq_idx_o), 40);
        rd(bk(2, 5), d); chk("R4 fast status", d, 32'h40);
        rd(bk(2, 4), d); chk("R4 normal status", d, 0);
        rd(bk(2, 6), d); chk("R4 route readback", d, 32'h40);
        rd(12'h001, d); chk("R7 fast index word", d, 32'h8000_0346);
        rd(12'h003, d); chk("R7 fast vector", d, 32'h1000_0070);
        settle(); chk("R11 masked", 32'(fiq_o), 0);
        wr(12'h003, 32'h0); settle();
        chk("R11 unmasked", 32'(fiq_o), 1);
        wr(bk(2, 1), 32'h40); settle();
        chk("R2 fast cleared", 32'(fiq_o), 0);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        rd(12'h002, d); chk("R7 normal vector", d, 32'h1000_0040);
        settle(); chk("R9 taken drops", 32'(irq_o), 0);
        wr(12'h400 + 12'd9, 3); wr(bk(0, 2), 32'h200); wr(bk(0, 0), 32'h200);
        settle(); chk("R9 equal priority blocked", 32'(irq_o), 0);
        wr(12'h400 + 12'd200, 2); wr(bk(6, 2), 32'h100); wr(bk(6, 0), 32'h100);
        settle(); chk("R9 more urgent nests", 32'(irq_o), 1);
        chk("R9 nest idx", 32'(irq_idx_o), 200);
        rd(12'h002, d); chk("R7 nested vector", d, 32'h1000_0200);
        settle(); chk("R9 second level drops", 32'(irq_o), 0);
        wr(12'h002, 32'h0); settle();
        chk("R10 pop restores level", 32'(irq_o), 1);
        chk("R10 pop idx", 32'(irq_idx_o), 200);
        wr(bk(6, 1), 32'h100); settle();
        chk("R10 level 3 still held", 32'(irq_o), 0);
        wr(12'h002, 32'h0); settle();
        chk("R10 empty stack line", 32'(irq_o), 1);
        rd(12'h000, d); chk("R5 tie after unwind", d, 32'h8000_0309);
    endtask

    task automatic t_fallback_hw();
        logic [31:0] d;
        wr(bk(0, 1), 32'h200); wr(bk(1, 1), 32'h100);
        wr(12'h004, 32'hDEAD_BEEF); settle();
        chk("R8 idle line", 32'(irq_o), 0);
        rd(12'h002, d); chk("R8 fallback normal", d, 32'hDEAD_BEEF);
        rd(12'h003, d); chk("R8 fallback fast", d, 32'hDEAD_BEEF);
        rd(12'h001, d); chk("R7 invalid index word", d, 0);
        wr(12'h002, 32'h0);
        wr(bk(0, 0), 32'h20); settle();
        chk("R10 empty pop harmless", 32'(irq_o), 1);
        chk("R10 empty pop idx", 32'(irq_idx_o), 5);
        @(negedge clk); src_set[130] = 1'b1;
        @(negedge clk); src_set[130] = 1'b0;
        rd(bk(4, 0), d); chk("R1 hardware set", d, 32'h4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_set = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pending_enable();
        t_priority();
        t_route_fast();
        t_nest();
        t_fallback_hw();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule